// File: doc/BRIEF.md
# Fetch Direction and Target Predictor

This unit sits in the fetch stage of a pipelined core and proposes the address to fetch next. Each fetch address is looked up in two tables. A direction table of 2-bit saturating counters gives the expected outcome. A direct-mapped target cache holds a valid flag, a partial tag and a destination address for each entry. When the target cache hits and the counter leans towards taken, the unit returns the cached destination. Fetch can then follow a taken branch in the same cycle. In every other case it returns the sequential address, fetch PC plus 4.

Later in the pipeline the core reports each branch when it resolves: the branch address, whether it was taken, its real destination and the next address that was predicted for it. The unit trains both tables from this report. In the same cycle it flags a misprediction and gives the corrected fetch address. The core performs the flush itself.

Top module: `fpred_unit`

## Requirements
- R1: After reset every counter holds weakly-not-taken (01) and every target entry is invalid, so any fetch gives pred_taken = 0 and pred_next_pc = fetch_pc + 4.
- R2: A resolution at a given address steps that address's counter up by one for a taken outcome and down by one for a not-taken outcome. The counter saturates at 00 and 11. Encoding: 00 strong not-taken, 01 weak not-taken, 10 weak taken, 11 strong taken. Bit 1 is the predicted direction, so a strong state needs two contrary outcomes in a row before the prediction flips.
- R3: A taken resolution writes its target entry: valid set, tag stored, destination stored. A not-taken resolution leaves the target cache unchanged.
- R4: pred_taken = 1 and pred_next_pc equals the cached destination exactly when the target entry hits and counter bit 1 is set.
- R5: On a target miss, or when counter bit 1 is clear, pred_taken = 0 and pred_next_pc = fetch_pc + 4.
- R6: mispredict rises in the cycle of a resolution exactly when the correct next address differs from res_pred_npc. It stays low in cycles with no resolution.
- R7: redirect_pc equals res_target for a taken resolution and res_pc + 4 for a not-taken one.
- R8: When a fetch lookup and a resolution update address the same entries in one cycle, the lookup returns the state from before the update. The update shows from the next cycle.
- R9: Direction index is pc[7:2], target index is pc[5:2] and the target tag is pc[13:6]. A stored tag that differs from the fetch tag is a miss, even when the direction index matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| fetch_pc | input | 32 | Address being fetched this cycle |
| pred_taken | output | 1 | Lookup predicts a taken branch with a known target |
| pred_next_pc | output | 32 | Proposed next fetch address |
| res_valid | input | 1 | A branch resolves this cycle |
| res_pc | input | 32 | Address of the resolving branch |
| res_taken | input | 1 | Actual outcome of the branch |
| res_target | input | 32 | Actual destination when taken |
| res_pred_npc | input | 32 | Next address predicted for this branch at fetch |
| mispredict | output | 1 | Prediction was wrong; fetch must be redirected |
| redirect_pc | output | 32 | Correct next fetch address for the resolving branch |

## Verification
A fetch lookup and a training update can land on the same entries in one clock cycle. The bench forces this by putting the same address on fetch_pc and res_pc in a directed cycle. In that cycle it expects the prediction from the state before the update, taken from a weakly-taken counter that the same cycle's not-taken outcome demotes. It then expects the demoted result one cycle later. The random phase draws fetch and resolution addresses from a small shared pool, including addresses that alias in the index but not in the tag. Collisions of this kind occur often, and every one is scored against a reference model that applies updates only after the lookup has been scored.

// File: rtl/fpred_pkg.sv
package fpred_pkg;

   typedef logic [1:0] ctr_t;

   localparam ctr_t CTR_SNT = 2'b00;
   localparam ctr_t CTR_WNT = 2'b01;
   localparam ctr_t CTR_WT  = 2'b10;
   localparam ctr_t CTR_ST  = 2'b11;

   // saturating step of a direction counter
   function automatic ctr_t ctr_step(input ctr_t cur, input logic taken);
      ctr_t nxt;
      if (taken) nxt = (cur == CTR_ST)  ? CTR_ST  : cur + 2'd1;
      else       nxt = (cur == CTR_SNT) ? CTR_SNT : cur - 2'd1;
      return nxt;
   endfunction

endpackage

// File: rtl/fpred_dir_table.sv
module fpred_dir_table
   import fpred_pkg::*;
#(
   parameter int ENTRIES = 64,
   parameter int IDX_W   = $clog2(ENTRIES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   output ctr_t             rd_ctr,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic             wr_taken
);

   ctr_t tbl [ENTRIES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < ENTRIES; i++) tbl[i] <= CTR_WNT;
      end else if (wr_en) begin
         tbl[wr_idx] <= ctr_step(tbl[wr_idx], wr_taken);
      end
   end

   // lookup sees the registered state, so a same-cycle write is invisible
   assign rd_ctr = tbl[rd_idx];

endmodule

// File: rtl/fpred_tgt_cache.sv
module fpred_tgt_cache #(
   parameter int ENTRIES = 16,
   parameter int IDX_W   = $clog2(ENTRIES),
   parameter int TAG_W   = 8,
   parameter int PC_W    = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   input  logic [TAG_W-1:0] rd_tag,
   output logic             rd_hit,
   output logic [PC_W-1:0]  rd_target,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [TAG_W-1:0] wr_tag,
   input  logic [PC_W-1:0]  wr_target
);

   logic [ENTRIES-1:0] ent_vld;
   logic [TAG_W-1:0]   ent_tag [ENTRIES];
   logic [PC_W-1:0]    ent_tgt [ENTRIES];

   for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
      logic             sel;
      logic             vld_q;
      logic [TAG_W-1:0] tag_q;
      logic [PC_W-1:0]  tgt_q;

      assign sel = wr_en && (wr_idx == IDX_W'(e));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   vld_q <= 1'b0;
         else if (sel) vld_q <= 1'b1;
      end

      always_ff @(posedge clk) begin
         if (sel) begin
            tag_q <= wr_tag;
            tgt_q <= wr_target;
         end
      end

      assign ent_vld[e] = vld_q;
      assign ent_tag[e] = tag_q;
      assign ent_tgt[e] = tgt_q;
   end

   assign rd_hit    = ent_vld[rd_idx] && (ent_tag[rd_idx] == rd_tag);
   assign rd_target = ent_tgt[rd_idx];

endmodule

// File: rtl/fpred_resolve.sv
module fpred_resolve #(
   parameter int PC_W = 32
) (
   input  logic            res_valid,
   input  logic [PC_W-1:0] res_pc,
   input  logic            res_taken,
   input  logic [PC_W-1:0] res_target,
   input  logic [PC_W-1:0] res_pred_npc,
   output logic            mispredict,
   output logic [PC_W-1:0] redirect_pc
);

   localparam logic [PC_W-1:0] STEP = PC_W'(4);

   logic [PC_W-1:0] good_npc;

   always_comb begin
      good_npc    = res_taken ? res_target : (res_pc + STEP);
      redirect_pc = good_npc;
      mispredict  = res_valid && (good_npc != res_pred_npc);
   end

endmodule

// File: rtl/fpred_unit.sv
module fpred_unit
   import fpred_pkg::*;
#(
   parameter int PC_W        = 32,
   parameter int DIR_ENTRIES = 64,
   parameter int TGT_ENTRIES = 16,
   parameter int TAG_W       = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PC_W-1:0] fetch_pc,
   output logic            pred_taken,
   output logic [PC_W-1:0] pred_next_pc,
   input  logic            res_valid,
   input  logic [PC_W-1:0] res_pc,
   input  logic            res_taken,
   input  logic [PC_W-1:0] res_target,
   input  logic [PC_W-1:0] res_pred_npc,
   output logic            mispredict,
   output logic [PC_W-1:0] redirect_pc
);

   localparam int DIR_IDX_W = $clog2(DIR_ENTRIES);
   localparam int TGT_IDX_W = $clog2(TGT_ENTRIES);
   localparam int IDX_LO    = 2;
   localparam int TAG_LO    = IDX_LO + TGT_IDX_W;
   localparam logic [PC_W-1:0] STEP = PC_W'(4);

   if ((1 << DIR_IDX_W) != DIR_ENTRIES || (1 << TGT_IDX_W) != TGT_ENTRIES) begin : g_bad_depth
      $error("fpred_unit: table depths must be powers of two");
   end
   if (PC_W < TAG_LO + TAG_W || PC_W < IDX_LO + DIR_IDX_W) begin : g_bad_width
      $error("fpred_unit: PC_W too narrow for index and tag fields");
   end
   if (TAG_W < 1 || DIR_ENTRIES < 2 || TGT_ENTRIES < 2) begin : g_bad_size
      $error("fpred_unit: tag width and table depths out of range");
   end

   // fetch side fields
   logic [DIR_IDX_W-1:0] f_dir_idx;
   logic [TGT_IDX_W-1:0] f_tgt_idx;
   logic [TAG_W-1:0]     f_tag;
   // resolve side fields
   logic [DIR_IDX_W-1:0] r_dir_idx;
   logic [TGT_IDX_W-1:0] r_tgt_idx;
   logic [TAG_W-1:0]     r_tag;

   assign f_dir_idx = fetch_pc[IDX_LO +: DIR_IDX_W];
   assign f_tgt_idx = fetch_pc[IDX_LO +: TGT_IDX_W];
   assign f_tag     = fetch_pc[TAG_LO +: TAG_W];
   assign r_dir_idx = res_pc[IDX_LO +: DIR_IDX_W];
   assign r_tgt_idx = res_pc[IDX_LO +: TGT_IDX_W];
   assign r_tag     = res_pc[TAG_LO +: TAG_W];

   ctr_t            dir_ctr;
   logic            tgt_hit;
   logic [PC_W-1:0] tgt_addr;

   fpred_dir_table #(
      .ENTRIES (DIR_ENTRIES),
      .IDX_W   (DIR_IDX_W)
   ) u_dir (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_idx   (f_dir_idx),
      .rd_ctr   (dir_ctr),
      .wr_en    (res_valid),
      .wr_idx   (r_dir_idx),
      .wr_taken (res_taken)
   );

   fpred_tgt_cache #(
      .ENTRIES (TGT_ENTRIES),
      .IDX_W   (TGT_IDX_W),
      .TAG_W   (TAG_W),
      .PC_W    (PC_W)
   ) u_tgt (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_idx    (f_tgt_idx),
      .rd_tag    (f_tag),
      .rd_hit    (tgt_hit),
      .rd_target (tgt_addr),
      .wr_en     (res_valid && res_taken),
      .wr_idx    (r_tgt_idx),
      .wr_tag    (r_tag),
      .wr_target (res_target)
   );

   fpred_resolve #(
      .PC_W (PC_W)
   ) u_res (
      .res_valid    (res_valid),
      .res_pc       (res_pc),
      .res_taken    (res_taken),
      .res_target   (res_target),
      .res_pred_npc (res_pred_npc),
      .mispredict   (mispredict),
      .redirect_pc  (redirect_pc)
   );

   always_comb begin
      pred_taken   = tgt_hit && dir_ctr[1];
      pred_next_pc = pred_taken ? tgt_addr : (fetch_pc + STEP);
   end

endmodule

// File: rtl/fpred_chk.sv
module fpred_chk #(
   parameter int PC_W = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic [PC_W-1:0] fetch_pc,
   input logic            pred_taken,
   input logic [PC_W-1:0] pred_next_pc,
   input logic            res_valid,
   input logic [PC_W-1:0] res_pc,
   input logic            res_taken,
   input logic [PC_W-1:0] res_target,
   input logic [PC_W-1:0] res_pred_npc,
   input logic            mispredict,
   input logic [PC_W-1:0] redirect_pc
);

   localparam logic [PC_W-1:0] STEP = PC_W'(4);

   // R5: no taken prediction means sequential fetch
   a_r5_seq_fetch: assert property (@(posedge clk) disable iff (!rst_n)
      !pred_taken |-> (pred_next_pc == fetch_pc + STEP));

   // R6: no resolution, no misprediction flag
   a_r6_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !res_valid |-> !mispredict);

   // R6: a correct prediction never flags
   a_r6_correct: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !res_taken && res_pred_npc == res_pc + STEP) |-> !mispredict);

   // R7: flagged taken branch redirects to its real destination
   a_r7_redirect: assert property (@(posedge clk) disable iff (!rst_n)
      (mispredict && res_taken) |-> (redirect_pc == res_target));

   // R2/R3: two taken outcomes in a row at one address make that address predict taken to the new target
   a_r3_learn: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(res_valid && res_taken, 2) && $past(res_valid && res_taken)
       && $past(res_pc, 2) == $past(res_pc) && fetch_pc == $past(res_pc))
      |-> (pred_taken && pred_next_pc == $past(res_target)));

endmodule

bind fpred_unit fpred_chk #(.PC_W(PC_W)) u_chk (.*);

// File: tb/fpred_unit_tb.sv
`timescale 1ns/1ps
module fpred_unit_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] fetch_pc = '0;
   logic        pred_taken;
   logic [31:0] pred_next_pc;
   logic        res_valid = 1'b0;
   logic [31:0] res_pc = '0;
   logic        res_taken = 1'b0;
   logic [31:0] res_target = '0;
   logic [31:0] res_pred_npc = '0;
   logic        mispredict;
   logic [31:0] redirect_pc;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // reference state
   logic [1:0]  m_ctr [64];
   logic        m_vld [16];
   logic [7:0]  m_tag [16];
   logic [31:0] m_tgt [16];

   always #10 clk = ~clk;

   fpred_unit u_dut (
      .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc),
      .pred_taken(pred_taken), .pred_next_pc(pred_next_pc),
      .res_valid(res_valid), .res_pc(res_pc), .res_taken(res_taken),
      .res_target(res_target), .res_pred_npc(res_pred_npc),
      .mispredict(mispredict), .redirect_pc(redirect_pc)
   );

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic m_hit(input logic [31:0] pc);
      return m_vld[pc[5:2]] && (m_tag[pc[5:2]] == pc[13:6]);
   endfunction

   function automatic logic m_taken(input logic [31:0] pc);
      return m_hit(pc) && m_ctr[pc[7:2]][1];
   endfunction

   function automatic logic [31:0] m_npc(input logic [31:0] pc);
      return m_taken(pc) ? m_tgt[pc[5:2]] : pc + 32'd4;
   endfunction

   function automatic logic [31:0] good_npc(input logic tk, input logic [31:0] pc, input logic [31:0] tg);
      return tk ? tg : pc + 32'd4;
   endfunction

   task automatic m_update();
      if (res_valid) begin
         if (res_taken && m_ctr[res_pc[7:2]] != 2'b11) m_ctr[res_pc[7:2]] = m_ctr[res_pc[7:2]] + 2'd1;
         if (!res_taken && m_ctr[res_pc[7:2]] != 2'b00) m_ctr[res_pc[7:2]] = m_ctr[res_pc[7:2]] - 2'd1;
         if (res_taken) begin
            m_vld[res_pc[5:2]] = 1'b1;
            m_tag[res_pc[5:2]] = res_pc[13:6];
            m_tgt[res_pc[5:2]] = res_target;
         end
      end
   endtask

   // one cycle: drive at negedge, score before the edge, then train the model
   task automatic cyc(input string req, input logic [31:0] fpc, input logic rv,
                      input logic [31:0] rpc, input logic rt, input logic [31:0] rtg,
                      input logic [31:0] rnpc);
      logic [31:0] gn;
      fetch_pc = fpc; res_valid = rv; res_pc = rpc; res_taken = rt;
      res_target = rtg; res_pred_npc = rnpc;
      #2;
      gn = good_npc(rt, rpc, rtg);
      chk(req, "pred_taken", {31'd0, pred_taken}, {31'd0, m_taken(fpc)});
      chk(req, "pred_next_pc", pred_next_pc, m_npc(fpc));
      chk(req, "mispredict", {31'd0, mispredict}, {31'd0, rv && (gn != rnpc)});
      if (rv) chk(req, "redirect_pc", redirect_pc, gn);
      @(posedge clk);
      m_update();
      @(negedge clk);
   endtask

   localparam logic [31:0] A  = 32'h0000_1040;
   localparam logic [31:0] TA = 32'h0000_8800;
   localparam logic [31:0] B  = A ^ 32'h0000_0100;   // same indices, other tag

   initial begin : watchdog
      #(20 * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired actual running expected finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : stim
      logic [31:0] pool [8];
      for (int i = 0; i < 64; i++) m_ctr[i] = 2'b01;
      for (int i = 0; i < 16; i++) begin m_vld[i] = 1'b0; m_tag[i] = '0; m_tgt[i] = '0; end
      void'($urandom(32'd20240607));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: clean state predicts sequential fetch everywhere
      cyc("R1", A, 1'b0, 0, 1'b0, 0, 0);
      cyc("R1", 32'hFFFF_FFFC, 1'b0, 0, 1'b0, 0, 0);
      // R6 R7: first taken outcome was predicted sequential
      cyc("R6 R7", A, 1'b1, A, 1'b1, TA, A + 4);
      // R3 R4: counter 10 and entry filled -> jump to TA
      cyc("R3 R4", A, 1'b0, 0, 1'b0, 0, 0);
      cyc("R2 R6", A, 1'b1, A, 1'b1, TA, TA);          // to 11, correct
      cyc("R7", A, 1'b1, A, 1'b0, TA, TA);             // to 10, redirect A+4
      cyc("R2", A, 1'b0, 0, 1'b0, 0, 0);               // still taken
      cyc("R3", A, 1'b1, A, 1'b0, TA, TA);             // to 01, entry kept
      cyc("R2 R5", A, 1'b0, 0, 1'b0, 0, 0);            // hit but not taken
      cyc("R2", A, 1'b1, A, 1'b0, 0, A + 4);           // to 00
      cyc("R2", A, 1'b1, A, 1'b0, 0, A + 4);           // stays 00
      cyc("R2", A, 1'b1, A, 1'b1, TA, A + 4);          // to 01
      cyc("R2", A, 1'b1, A, 1'b1, TA, A + 4);          // to 10
      // R8: same-cycle lookup sees 10 while update writes 01
      cyc("R8", A, 1'b1, A, 1'b0, TA, TA);
      cyc("R8", A, 1'b0, 0, 1'b0, 0, 0);
      // R9: aliasing address shares counter but misses the tag
      cyc("R9", A, 1'b1, A, 1'b1, TA, A + 4);
      cyc("R9", A, 1'b1, A, 1'b1, TA, TA);
      cyc("R9", B, 1'b0, 0, 1'b0, 0, 0);
      cyc("R9", B, 1'b1, B, 1'b1, 32'h0000_4000, B + 4);
      cyc("R9", A, 1'b0, 0, 1'b0, 0, 0);

      // constrained random phase
      pool[0] = A; pool[1] = B; pool[2] = 32'h0000_0200; pool[3] = 32'h0000_0204;
      pool[4] = 32'h0000_3A40; pool[5] = 32'h0000_0240; pool[6] = 32'h0001_0008;
      pool[7] = 32'h0000_1044;
      for (int n = 0; n < 4000; n++) begin
         logic [31:0] f, r, t, np;
         logic        v, k;
         f = pool[$urandom_range(0, 7)];
         v = ($urandom_range(0, 3) != 0);
         r = ($urandom_range(0, 3) == 0) ? f : pool[$urandom_range(0, 7)];
         k = $urandom_range(0, 1);
         t = {$urandom_range(0, 32'h3FFF_FFFF), 2'b00};
         if ($urandom_range(0, 7) == 0) t = m_tgt[r[5:2]];
         np = ($urandom_range(0, 1) == 1) ? m_npc(r) : good_npc(k, r, t);
         if ($urandom_range(0, 9) == 0) np = {$urandom_range(0, 32'h3FFF_FFFF), 2'b00};
         cyc("R2 R4 R5 R6 R8", f, v, r, k, t, np);
      end

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule